// File: doc/BRIEF.md
# Segment Register Descriptor Cache Checker

This block models one data segment register. It has a visible selector and a hidden copy of the descriptor that the selector names. A load request carries a new selector. The block then reads the 8-byte descriptor from a descriptor table in memory. The entry address is the table base plus the selector's index field times eight, and the block reads it as two 32-bit words. It decides whether the load is allowed from the present flag and the privilege levels. If the load is allowed, it keeps the base, limit, type and privilege level of that descriptor.

After a successful load, every access gives only an offset and a kind (read, write or execute). No descriptor memory traffic takes place. The block compares the offset with the cached limit and the kind with the cached type bits. It then returns a registered result: either a linear address (base plus offset) or a fault code.

While a descriptor fetch is in flight, the block holds off new loads and new accesses through a ready/valid handshake.

Top module: `segc_top`

## Requirements
- R1: After reset, `load_ready_o` and `acc_ready_o` are 1, and `busy_o`, `mem_req_o`, `ld_done_o` and `res_valid_o` are 0. `sel_o` is 0 and no descriptor is cached. An access made before any successful load returns fault code 1.
- R2: An accepted load reads the low word at `tbl_base_i + (load_sel_i >> 2) * 8` first, then the high word at that address plus 4. `mem_req_o` and `mem_addr_o` are held until `mem_rvalid_i` returns the word.
- R3: Descriptor fields, as low word / high word:
  - base = {hi[31:24], hi[7:0], lo[31:16]}
  - limit = {hi[19:16], lo[15:0]}
  - type = hi[11:8]
  - privilege level = hi[14:13]
  - present flag = hi[15]
- R4: The current privilege level is `cs_sel_i[1:0]`, captured when the load is accepted. The requested level is `load_sel_i[1:0]`. If the larger of the two exceeds the descriptor's privilege level, the load ends with fault code 2.
- R5: A clear present flag ends the load with fault code 1, and this check wins over the privilege check. A load that faults changes neither `sel_o` nor the cached descriptor.
- R6: From the cycle after a load is accepted until the cycle `ld_done_o` is raised, `busy_o` is 1 and both `load_ready_o` and `acc_ready_o` are 0. An access held valid during that time is taken only afterwards, and it uses the newly cached descriptor.
- R7: An access whose offset is greater than the cached limit returns fault code 3 with `res_lin_o` = 0. This check wins over the type check.
- R8: Type bit 3 marks a code segment and type bit 1 means writable (data) or readable (code). Access kinds are 0 = read, 1 = write, 2 = execute. The following return fault code 4 (`res_lin_o` = 0):
  - a write to a code segment or to a data segment that is not writable;
  - a read of a code segment that is not readable;
  - an execute of a data segment;
  - kind 3.
- R9: An access accepted on a clock edge has its result on the next edge, with `res_valid_o` high for one cycle. On success the fault code is 0 and `res_lin_o` = (base + offset) mod 2^32.
- R10: A load raises `ld_done_o` for exactly one cycle together with `ld_fault_o`. On success, `sel_o` takes the loaded selector on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_sel_i | input | SEL_W | Code segment selector; low two bits are the current privilege level |
| tbl_base_i | input | AW | Byte address of descriptor table entry 0 |
| load_valid_i | input | 1 | Load request valid |
| load_sel_i | input | SEL_W | Selector to load |
| load_ready_o | output | 1 | Load request can be accepted |
| busy_o | output | 1 | Descriptor fetch in progress |
| ld_done_o | output | 1 | Load finished (one-cycle pulse) |
| ld_fault_o | output | 3 | Load result: 0 ok, 1 not present, 2 privilege |
| sel_o | output | SEL_W | Visible selector of the last successful load |
| mem_req_o | output | 1 | Descriptor word read request |
| mem_addr_o | output | AW | Descriptor word byte address |
| mem_rvalid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Read data word |
| acc_valid_i | input | 1 | Access request valid |
| acc_kind_i | input | 2 | 0 read, 1 write, 2 execute |
| acc_off_i | input | 32 | Access offset |
| acc_ready_o | output | 1 | Access request can be accepted |
| res_valid_o | output | 1 | Access result valid |
| res_fault_o | output | 3 | 0 ok, 1 no descriptor, 3 limit, 4 type |
| res_lin_o | output | 32 | Linear address on success, else 0 |

## Verification
The bench uses the defaults: 16-bit selectors and a 32-bit table address. This puts a table at a nonzero base within reach, and the base-plus-offset wrap at the top of the 32-bit space. The memory model's latency changes between loads, so the request-hold rule is exercised with one-cycle and multi-cycle returns. The descriptors cover these cases:
- read-write data, read-only data and not-present data;
- execute-only and readable code;
- a full 20-bit limit.

Together they reach every fault code, both check orders (present before privilege, limit before type), and a privilege fault raised by each of the two levels.

// File: rtl/segc_pkg.sv
package segc_pkg;
  localparam int WORD_W   = 32;
  localparam int LIMIT_W  = 20;
  localparam int TYPE_W   = 4;
  localparam int DPL_W    = 2;
  localparam int TYPE_EXEC_BIT = 3;
  localparam int TYPE_RW_BIT   = 1;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_NOTPRES = 3'd1,
    FLT_PRIV    = 3'd2,
    FLT_LIMIT   = 3'd3,
    FLT_TYPE    = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  typedef struct packed {
    logic [WORD_W-1:0]  base;
    logic [LIMIT_W-1:0] limit;
    logic [TYPE_W-1:0]  kind;
    logic [DPL_W-1:0]   dpl;
    logic               present;
  } desc_t;

  // Assemble the cached view from the two table words.
  function automatic desc_t unpack_desc(input logic [WORD_W-1:0] lo,
                                        input logic [WORD_W-1:0] hi);
    desc_t d;
    d.base    = {hi[31:24], hi[7:0], lo[31:16]};
    d.limit   = {hi[19:16], lo[15:0]};
    d.kind    = hi[11:8];
    d.dpl     = hi[14:13];
    d.present = hi[15];
    return d;
  endfunction
endpackage

// File: rtl/segc_rule.sv
module segc_rule
  import segc_pkg::*;
(
  input  desc_t            desc_i,
  input  logic [DPL_W-1:0] cpl_i,
  input  logic [DPL_W-1:0] rpl_i,
  output fault_e           fault_o
);
  logic [DPL_W-1:0] eff_lvl;

  // The less privileged (numerically larger) level governs.
  assign eff_lvl = (cpl_i > rpl_i) ? cpl_i : rpl_i;

  always_comb begin
    if (!desc_i.present)             fault_o = FLT_NOTPRES;
    else if (eff_lvl > desc_i.dpl)   fault_o = FLT_PRIV;
    else                             fault_o = FLT_NONE;
  end
endmodule

// File: rtl/segc_fetch.sv
module segc_fetch
  import segc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DPL_W-1:0] cpl_i,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic             load_valid_i,
  input  logic [SEL_W-1:0] load_sel_i,
  output logic             load_ready_o,
  output logic             busy_o,
  output logic             ld_done_o,
  output fault_e           ld_fault_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output desc_t            cache_o,
  output logic             cache_vld_o
);
  localparam int ENTRY_SHIFT = 3;
  localparam int OFS_W       = SEL_W - DPL_W + ENTRY_SHIFT;
  localparam logic [AW-1:0] HI_STEP = AW'(WORD_W / 8);

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} st_e;

  st_e               st_q;
  logic [SEL_W-1:0]  sel_pend_q, sel_q;
  logic [DPL_W-1:0]  cpl_pend_q;
  logic [WORD_W-1:0] lo_q;
  logic [AW-1:0]     addr_q;
  desc_t             cache_q;
  logic              cache_vld_q;
  logic              done_q;
  fault_e            flt_q;
  desc_t             fetched;
  fault_e            verdict;
  logic [OFS_W-1:0]  entry_ofs;

  assign fetched   = unpack_desc(lo_q, mem_rdata_i);
  assign entry_ofs = {load_sel_i[SEL_W-1:DPL_W], {ENTRY_SHIFT{1'b0}}};

  segc_rule u_rule (
    .desc_i  (fetched),
    .cpl_i   (cpl_pend_q),
    .rpl_i   (sel_pend_q[DPL_W-1:0]),
    .fault_o (verdict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      sel_pend_q  <= '0;
      sel_q       <= '0;
      cpl_pend_q  <= '0;
      lo_q        <= '0;
      addr_q      <= '0;
      cache_q     <= '0;
      cache_vld_q <= 1'b0;
      done_q      <= 1'b0;
      flt_q       <= FLT_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (load_valid_i) begin
            sel_pend_q <= load_sel_i;
            cpl_pend_q <= cpl_i;
            addr_q     <= tbl_base_i + AW'(entry_ofs);
            st_q       <= ST_LO;
          end
        end
        ST_LO: begin
          if (mem_rvalid_i) begin
            lo_q   <= mem_rdata_i;
            addr_q <= addr_q + HI_STEP;
            st_q   <= ST_HI;
          end
        end
        ST_HI: begin
          if (mem_rvalid_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
            flt_q  <= verdict;
            if (verdict == FLT_NONE) begin
              cache_q     <= fetched;
              cache_vld_q <= 1'b1;
              sel_q       <= sel_pend_q;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_ready_o = (st_q == ST_IDLE);
  assign busy_o       = (st_q != ST_IDLE);
  assign mem_req_o    = (st_q == ST_LO) || (st_q == ST_HI);
  assign mem_addr_o   = addr_q;
  assign ld_done_o    = done_q;
  assign ld_fault_o   = flt_q;
  assign sel_o        = sel_q;
  assign cache_o      = cache_q;
  assign cache_vld_o  = cache_vld_q;

  // R2: an outstanding word read keeps its request and address.
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R5: a refused load leaves the visible selector and the cache alone.
  assert_keep_on_fault_R5: assert property (@(posedge clk) disable iff (rst)
    (ld_done_o && ld_fault_o != FLT_NONE) |-> ($stable(sel_o) && $stable(cache_q)));

  // R6: an accepted load makes the block busy on the next cycle.
  assert_busy_after_load_R6: assert property (@(posedge clk) disable iff (rst)
    (load_valid_i && load_ready_o) |=> (busy_o && !load_ready_o));

  // R10: completion is a single-cycle pulse.
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    ld_done_o |=> !ld_done_o);
endmodule

// File: rtl/segc_access.sv
module segc_access
  import segc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_fire_i,
  input  logic [1:0]        acc_kind_i,
  input  logic [WORD_W-1:0] acc_off_i,
  input  desc_t             cache_i,
  input  logic              cache_vld_i,
  output logic              res_valid_o,
  output fault_e            res_fault_o,
  output logic [WORD_W-1:0] res_lin_o
);
  logic   is_code, rw_bit, type_ok, over_limit;
  fault_e verdict;

  assign is_code    = cache_i.kind[TYPE_EXEC_BIT];
  assign rw_bit     = cache_i.kind[TYPE_RW_BIT];
  assign over_limit = acc_off_i > WORD_W'(cache_i.limit);

  always_comb begin
    unique case (acc_kind_i)
      ACC_READ:  type_ok = !is_code || rw_bit;
      ACC_WRITE: type_ok = !is_code && rw_bit;
      ACC_EXEC:  type_ok = is_code;
      default:   type_ok = 1'b0;
    endcase
  end

  always_comb begin
    if (!cache_vld_i)   verdict = FLT_NOTPRES;
    else if (over_limit) verdict = FLT_LIMIT;
    else if (!type_ok)  verdict = FLT_TYPE;
    else                verdict = FLT_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o <= 1'b0;
      res_fault_o <= FLT_NONE;
      res_lin_o   <= '0;
    end else begin
      res_valid_o <= acc_fire_i;
      if (acc_fire_i) begin
        res_fault_o <= verdict;
        res_lin_o   <= (verdict == FLT_NONE) ? cache_i.base + acc_off_i : '0;
      end
    end
  end

  // R7: an offset past a valid cached limit reports the limit fault.
  assert_limit_fault_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_fire_i && cache_vld_i && acc_off_i > WORD_W'(cache_i.limit))
      |=> (res_valid_o && res_fault_o == FLT_LIMIT && res_lin_o == '0));

  // R9: a clean result is the cached base plus the offset of the accepted access.
  assert_lin_sum_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid_o && res_fault_o == FLT_NONE)
      |-> (res_lin_o == $past(cache_i.base) + $past(acc_off_i)));
endmodule

// File: rtl/segc_top.sv
module segc_top
  import segc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int SEL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] cs_sel_i,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic             load_valid_i,
  input  logic [SEL_W-1:0] load_sel_i,
  output logic             load_ready_o,
  output logic             busy_o,
  output logic             ld_done_o,
  output logic [2:0]       ld_fault_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic             acc_valid_i,
  input  logic [1:0]       acc_kind_i,
  input  logic [31:0]      acc_off_i,
  output logic             acc_ready_o,
  output logic             res_valid_o,
  output logic [2:0]       res_fault_o,
  output logic [31:0]      res_lin_o
);
  desc_t  cache;
  logic   cache_vld;
  fault_e ld_fault, res_fault;
  logic   acc_fire;
  logic   unused_cs_hi;

  assign unused_cs_hi = ^cs_sel_i[SEL_W-1:DPL_W];

  segc_fetch #(.AW(AW), .SEL_W(SEL_W)) u_fetch (
    .clk          (clk),
    .rst          (rst),
    .cpl_i        (cs_sel_i[DPL_W-1:0]),
    .tbl_base_i   (tbl_base_i),
    .load_valid_i (load_valid_i),
    .load_sel_i   (load_sel_i),
    .load_ready_o (load_ready_o),
    .busy_o       (busy_o),
    .ld_done_o    (ld_done_o),
    .ld_fault_o   (ld_fault),
    .sel_o        (sel_o),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .cache_o      (cache),
    .cache_vld_o  (cache_vld)
  );

  // Accesses wait while the hidden descriptor is being refilled.
  assign acc_ready_o = !busy_o;
  assign acc_fire    = acc_valid_i && acc_ready_o;

  segc_access u_access (
    .clk         (clk),
    .rst         (rst),
    .acc_fire_i  (acc_fire),
    .acc_kind_i  (acc_kind_i),
    .acc_off_i   (acc_off_i),
    .cache_i     (cache),
    .cache_vld_i (cache_vld),
    .res_valid_o (res_valid_o),
    .res_fault_o (res_fault),
    .res_lin_o   (res_lin_o)
  );

  assign ld_fault_o  = ld_fault;
  assign res_fault_o = res_fault;

  // R6: no access result may come from a request made during a fetch.
  assert_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> !res_valid_o);
endmodule

// File: tb/tb_segc_top.sv
module tb_segc_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] TB_BASE = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cs_sel_i, load_sel_i, sel_o;
  logic [31:0] tbl_base_i, mem_addr_o, mem_rdata_i, acc_off_i, res_lin_o;
  logic        load_valid_i, load_ready_o, busy_o, ld_done_o, mem_req_o, mem_rvalid_i;
  logic        acc_valid_i, acc_ready_o, res_valid_o;
  logic [2:0]  ld_fault_o, res_fault_o;
  logic [1:0]  acc_kind_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  segc_top dut (
    .clk(clk), .rst(rst), .cs_sel_i(cs_sel_i), .tbl_base_i(tbl_base_i),
    .load_valid_i(load_valid_i), .load_sel_i(load_sel_i), .load_ready_o(load_ready_o),
    .busy_o(busy_o), .ld_done_o(ld_done_o), .ld_fault_o(ld_fault_o), .sel_o(sel_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i(mem_rdata_i), .acc_valid_i(acc_valid_i), .acc_kind_i(acc_kind_i),
    .acc_off_i(acc_off_i), .acc_ready_o(acc_ready_o), .res_valid_o(res_valid_o),
    .res_fault_o(res_fault_o), .res_lin_o(res_lin_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  typedef struct { logic [2:0] f; logic [31:0] lin; string tag; } acc_exp_t;
  typedef struct { logic [2:0] f; logic [15:0] sel; string tag; } ld_exp_t;
  acc_exp_t accq[$];
  ld_exp_t  ldq[$];
  logic [31:0] addr_log[$];
  logic [15:0] good_sel = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Descriptor table memory model with adjustable latency.
  logic [31:0] mem [0:31];
  int lat = 0;
  int cnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid_i <= 1'b0;
      mem_rdata_i  <= '0;
      cnt = 0;
    end else if (mem_req_o && !mem_rvalid_i) begin
      if (cnt >= lat) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= mem[((mem_addr_o - TB_BASE) >> 2) & 32'h1F];
        addr_log.push_back(mem_addr_o);
        cnt = 0;
      end else cnt = cnt + 1;
    end else begin
      mem_rvalid_i <= 1'b0;
    end
  end

  // R3 layout used to build each table entry.
  task automatic put_desc(input int n, input logic [31:0] b, input logic [19:0] lim,
                          input logic [3:0] ty, input logic [1:0] dpl, input logic p);
    mem[2*n]   = {b[15:0], lim[15:0]};
    mem[2*n+1] = {b[31:24], 4'b0100, lim[19:16], p, dpl, 1'b1, ty, b[23:16]};
  endtask

  // Scoreboard monitor.
  acc_exp_t ae;
  ld_exp_t  le;
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid_o) begin
        if (accq.size() == 0) chk(1'b0, "R9 unexpected access result", 32'(res_fault_o), 32'hFFFF_FFFF);
        else begin
          ae = accq.pop_front();
          chk(res_fault_o == ae.f, {ae.tag, " fault"}, 32'(res_fault_o), 32'(ae.f));
          chk(res_lin_o == ae.lin, {ae.tag, " linear"}, res_lin_o, ae.lin);
        end
      end
      if (ld_done_o) begin
        if (ldq.size() == 0) chk(1'b0, "R10 unexpected load done", 32'(ld_fault_o), 32'hFFFF_FFFF);
        else begin
          le = ldq.pop_front();
          chk(ld_fault_o == le.f, {le.tag, " load fault"}, 32'(ld_fault_o), 32'(le.f));
          chk(sel_o == le.sel, {le.tag, " selector"}, 32'(sel_o), 32'(le.sel));
        end
      end
    end
  end

  task automatic do_load(input int n, input logic [1:0] rpl, input logic [1:0] cpl,
                         input logic [2:0] expf, input string tag);
    logic [15:0] s;
    logic [31:0] lo_a;
    s = {n[13:0], rpl};
    lo_a = TB_BASE + 32'(n) * 8;
    if (expf == 3'd0) good_sel = s;
    ldq.push_back('{expf, good_sel, tag});
    addr_log.delete();
    @(negedge clk);
    cs_sel_i = {14'h2A5, cpl};
    load_sel_i = s;
    load_valid_i = 1'b1;
    @(negedge clk);
    load_valid_i = 1'b0;
    chk(busy_o && !load_ready_o && !acc_ready_o, "R6 busy after accept", 32'(busy_o), 32'd1);
    while (!ld_done_o) @(negedge clk);
    chk(load_ready_o && !busy_o, "R6 ready at done", 32'(load_ready_o), 32'd1);
    chk(addr_log.size() == 2, "R2 word count", 32'(addr_log.size()), 32'd2);
    if (addr_log.size() == 2) begin
      chk(addr_log[0] == lo_a, "R2 low word address", addr_log[0], lo_a);
      chk(addr_log[1] == lo_a + 4, "R2 high word address", addr_log[1], lo_a + 4);
    end
  endtask

  task automatic do_acc(input logic [1:0] k, input logic [31:0] off,
                        input logic [2:0] expf, input logic [31:0] explin, input string tag);
    accq.push_back('{expf, explin, tag});
    @(negedge clk);
    acc_kind_i = k;
    acc_off_i = off;
    acc_valid_i = 1'b1;
    @(negedge clk);
    acc_valid_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit stall_bad;
    for (int i = 0; i < 32; i++) mem[i] = '0;
    put_desc(1, 32'h1000_0000, 20'h00FFF, 4'b0010, 2'd3, 1'b1);
    put_desc(2, 32'h2000_0000, 20'h0FFFF, 4'b0000, 2'd2, 1'b1);
    put_desc(3, 32'h3000_0000, 20'h00FFF, 4'b0010, 2'd3, 1'b0);
    put_desc(4, 32'h4000_0000, 20'h001FF, 4'b1000, 2'd3, 1'b1);
    put_desc(5, 32'h5000_0000, 20'h001FF, 4'b1010, 2'd0, 1'b1);
    put_desc(6, 32'hFFFF_F000, 20'hFFFFF, 4'b0010, 2'd3, 1'b1);
    put_desc(7, 32'h7000_0000, 20'h00FFF, 4'b0010, 2'd0, 1'b0);
    rst = 1'b1;
    cs_sel_i = '0; load_sel_i = '0; load_valid_i = 1'b0; tbl_base_i = TB_BASE;
    acc_valid_i = 1'b0; acc_kind_i = '0; acc_off_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(load_ready_o && acc_ready_o, "R1 ready after reset", 32'({load_ready_o, acc_ready_o}), 32'h3);
    chk(!busy_o && !mem_req_o && !ld_done_o && !res_valid_o, "R1 idle outputs",
        32'({busy_o, mem_req_o, ld_done_o, res_valid_o}), 32'h0);
    chk(sel_o == 16'h0, "R1 selector after reset", 32'(sel_o), 32'h0);
    do_acc(2'd0, 32'h0, 3'd1, 32'h0, "R1 access before load");

    // R4 RPL 3 equals DPL 3: allowed.
    do_load(1, 2'd3, 2'd0, 3'd0, "R4 load rw data");
    do_acc(2'd0, 32'h0,     3'd0, 32'h1000_0000, "R9 read at 0");
    do_acc(2'd1, 32'hFFF,   3'd0, 32'h1000_0FFF, "R9 write at limit");
    do_acc(2'd0, 32'h1000,  3'd3, 32'h0,         "R7 one past limit");
    do_acc(2'd2, 32'h10,    3'd4, 32'h0,         "R8 execute data");
    do_acc(2'd2, 32'h2000,  3'd3, 32'h0,         "R7 limit before type");
    do_acc(2'd3, 32'h0,     3'd4, 32'h0,         "R8 kind 3");

    lat = 3;
    do_load(2, 2'd3, 2'd0, 3'd2, "R4 rpl above dpl");
    do_acc(2'd0, 32'h4,     3'd0, 32'h1000_0004, "R5 cache kept after priv fault");
    do_load(2, 2'd0, 2'd3, 3'd2, "R4 cpl above dpl");
    lat = 1;
    do_load(2, 2'd2, 2'd2, 3'd0, "R4 levels equal dpl");
    do_acc(2'd1, 32'h0,     3'd4, 32'h0,         "R8 write read-only data");
    do_acc(2'd0, 32'hFFFF,  3'd0, 32'h2000_FFFF, "R9 read read-only data");

    do_load(3, 2'd0, 2'd0, 3'd1, "R5 not present");
    do_acc(2'd0, 32'h0,     3'd0, 32'h2000_0000, "R5 cache kept after np fault");
    do_load(7, 2'd3, 2'd3, 3'd1, "R5 present checked first");

    lat = 0;
    do_load(4, 2'd0, 2'd0, 3'd0, "R3 exec-only code");
    do_acc(2'd0, 32'h0,     3'd4, 32'h0,         "R8 read exec-only code");
    do_acc(2'd2, 32'h1FF,   3'd0, 32'h4000_01FF, "R8 execute code");
    do_acc(2'd1, 32'h0,     3'd4, 32'h0,         "R8 write code");
    do_load(5, 2'd0, 2'd0, 3'd0, "R4 ring 0 code");
    do_acc(2'd0, 32'h100,   3'd0, 32'h5000_0100, "R8 read readable code");

    // R6: access held valid through a fetch is taken afterwards with the new descriptor.
    lat = 2;
    good_sel = {14'd6, 2'd3};
    ldq.push_back('{3'd0, good_sel, "R6 load under stall"});
    accq.push_back('{3'd0, 32'h0000_0800, "R6 stalled access wraps"});
    @(negedge clk);
    cs_sel_i = 16'h0003; load_sel_i = good_sel; load_valid_i = 1'b1;
    @(negedge clk);
    load_valid_i = 1'b0;
    acc_kind_i = 2'd0; acc_off_i = 32'h1800; acc_valid_i = 1'b1;
    stall_bad = 0;
    do begin
      if (res_valid_o || acc_ready_o) stall_bad = 1;
      @(negedge clk);
    end while (!ld_done_o);
    chk(!stall_bad, "R6 no result while busy", 32'(stall_bad), 32'd0);
    @(negedge clk);
    acc_valid_i = 1'b0;
    do_acc(2'd0, 32'hFFFFF,  3'd0, 32'h000F_EFFF, "R9 full limit wraps");
    do_acc(2'd0, 32'h100000, 3'd3, 32'h0,         "R7 past full limit");

    repeat (4) @(negedge clk);
    chk(accq.size() == 0, "R9 all access results seen", 32'(accq.size()), 32'd0);
    chk(ldq.size() == 0, "R10 all loads completed", 32'(ldq.size()), 32'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule